// File: doc/BRIEF.md
# Rotating-Priority Bus Grant Arbiter

This block decides which of N bus masters may drive a shared parallel bus next. Every master has one request input and one grant output of its own. A master must win a new grant for each access it makes, so holding the bus once gives it no right to the next access. The arbiter looks at two bus status lines to tell whether the bus is busy: the framing line and the initiator-ready line. From these it knows when an access begins and when the bus goes idle again.

The choice of the next owner is made while the current access is still running. When one access ends, the next master already holds its grant and can start at once. Arbitration therefore costs bus cycles only when the bus has been idle.

Priority rotates. The master that owned the last access moves to the bottom of the order, so every master that keeps requesting has a bounded wait. When nobody requests, the grant stays parked on the last owner. A handover from one master to another always leaves one clock with no grant asserted.

Top module: `rr_bus_arbiter`

## Requirements
- R1: At most one bit of `gnt` is 1 in any cycle.
- R2: `gnt` never switches directly from one master to a different one. Between them there is exactly one cycle with `gnt` all zero, and the following cycle asserts a grant.
- R3: While `req` is all zero, an asserted grant stays where it is. After a burst of activity ends, the grant rests on the master that owned the last access.
- R4: After an access by master k, the next master chosen is the first requester in the order k+1, k+2, …, N-1, 0, …, k. This order wraps around, and k itself is taken last.
- R5: An access by master i begins at a rising clock edge where all of these hold: `frm_act`=0, `rdy_act`=0, `gnt[i]`=1 and `req[i]`=1. A parked master that requests therefore starts without waiting for re-arbitration.
- R6: Suppose the next master was already requesting when the current access began. Then its grant is in place before the bus goes idle, and its access starts on the first idle cycle, with zero extra idle cycles.
- R7: A master that keeps requesting waits for at most N-1 accesses by other masters before it gets its own.
- R8: A master that is the only requester keeps its grant with no gap. This lets it run accesses back to back.
- R9: During and right after reset, `gnt` is 1 for master 0 only (`gnt`=1). Rotation after reset starts at master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | Request line of each master, active high, bit i belongs to master i |
| frm_act | input | 1 | Framing line of the bus is asserted (active high view) |
| rdy_act | input | 1 | Initiator-ready line of the bus is asserted (active high view) |
| gnt | output | N | Grant line of each master, active high, at most one set |

## Verification
A wrong owner pointer does not show up as a bad grant right away. It shows up as an out-of-order owner at the next access, so the check compares every access start against an expected order from a rotating model. A stuck or mistimed grant-valid state shows up at the ports within one cycle, as two grants at once, a direct handover with no gap, or a gap longer than one cycle. Slow handover logic shows up as an idle cycle before an access that should have started at once. Each access start also tracks how many other accesses every requester has waited through.

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         frm_act,
  input  logic         rdy_act,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] gidx, owner, base, win;
  logic          gval, any_req, bus_idle, acc_start;

  assign bus_idle  = !frm_act && !rdy_act;
  assign acc_start = bus_idle && gval && req[gidx];
  assign base      = acc_start ? gidx : owner;
  assign any_req   = |req;

  always_comb begin
    win = base;
    for (int k = N; k >= 1; k--) begin
      if (req[(int'(base) + k) % N]) win = IW'((int'(base) + k) % N);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gval  <= 1'b1;
      gidx  <= '0;
      owner <= IW'(N - 1);
    end else begin
      if (acc_start) owner <= gidx;
      if (gval) begin
        if (any_req && win != gidx) gval <= 1'b0;
      end else begin
        gval <= 1'b1;
        gidx <= any_req ? win : base;
      end
    end
  end

  always_comb begin
    gnt = '0;
    if (gval) gnt[gidx] = 1'b1;
  end
endmodule

// File: rtl/rr_bus_arbiter_chk.sv
module rr_bus_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] gnt
);
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_no_direct_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && (|$past(gnt))) |-> (gnt == $past(gnt)));

  p_single_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |=> (gnt != '0));

  p_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0 && gnt != '0) |=> (gnt == $past(gnt)));

  p_sole_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(req) == 1 && (req & gnt) != '0) |=> (gnt == $past(gnt)));
endmodule

bind rr_bus_arbiter rr_bus_arbiter_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt)
);

// File: tb/tb_rr_bus_arbiter.sv
`timescale 1ns/1ps
module tb_rr_bus_arbiter;
  localparam int N   = 4;
  localparam int LEN = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req, gnt;
  logic         frm_act = 1'b0, rdy_act = 1'b0;

  int want[N];
  int waited[N];
  int exp_q[$];
  int nchk = 0, nerr = 0, ncyc = 0;
  int parked = 0, last_own = N - 1;
  int idle_cnt = 0, busy = 0, pend_own = 0;
  bit pending = 1'b0, have_prev = 1'b0, done = 1'b0;
  bit prev_req[N];

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) req[i] = (want[i] > 0);

  rr_bus_arbiter #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .req(req),
    .frm_act(frm_act), .rdy_act(rdy_act), .gnt(gnt)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  task automatic start_seen(input int i);
    int e;
    pending  = 1'b1;
    pend_own = i;
    if (exp_q.size() == 0) chk(1'b0, "R4 unexpected access start", i, -1);
    else begin
      e = exp_q.pop_front();
      chk(i == e, "R4 next owner order (R5 start rule)", i, e);
    end
    if (have_prev && prev_req[i])
      chk(idle_cnt == 0, "R6 idle cycles before hidden-arbitrated access", idle_cnt, 0);
    chk(waited[i] <= N - 1, "R7 accesses waited by requester", waited[i], N - 1);
    waited[i] = 0;
    for (int j = 0; j < N; j++) begin
      if (j != i && want[j] > 0) waited[j]++;
      prev_req[j] = (want[j] > 0);
    end
    have_prev = 1'b1;
    idle_cnt  = 0;
  endtask

  // bus model and scoreboard monitor
  initial begin
    int found;
    for (int i = 0; i < N; i++) begin want[i] = 0; waited[i] = 0; prev_req[i] = 1'b0; end
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (pending) begin
        pending = 1'b0;
        frm_act = 1'b1;
        rdy_act = 1'b1;
        busy    = LEN;
        want[pend_own]--;
      end else if (busy > 0) begin
        busy--;
        if (busy == 1) frm_act = 1'b0;
        if (busy == 0) rdy_act = 1'b0;
      end
      if (!frm_act && !rdy_act) begin
        found = -1;
        for (int i = 0; i < N; i++) if (gnt[i] && want[i] > 0) found = i;
        if (found >= 0) start_seen(found);
        else idle_cnt++;
      end
    end
  end

  // grant handover monitor
  initial begin
    logic [N-1:0] prev;
    wait (rst_n);
    @(negedge clk);
    prev = gnt;
    forever begin
      @(negedge clk);
      if (gnt != prev) begin
        chk($countones(gnt) <= 1, "R1 grants asserted at once", $countones(gnt), 1);
        chk(!(prev != '0 && gnt != '0), "R2 direct handover without gap", int'(gnt), 0);
      end else if (gnt == '0) begin
        chk(1'b0, "R2 grant gap longer than one cycle", int'(gnt), 1);
      end
      prev = gnt;
    end
  end

  task automatic run4(input int a, input int b, input int c, input int d);
    int cnt[N];
    int l, p, left;
    cnt[0] = a; cnt[1] = b; cnt[2] = c; cnt[3] = d;
    p = parked;
    l = last_own;
    if (cnt[p] > 0) begin exp_q.push_back(p); cnt[p]--; l = p; end
    left = 0;
    for (int i = 0; i < N; i++) left += cnt[i];
    while (left > 0) begin
      for (int k = 1; k <= N; k++) begin
        if (cnt[(l + k) % N] > 0) begin
          l = (l + k) % N;
          exp_q.push_back(l);
          cnt[l]--;
          left--;
          break;
        end
      end
    end
    have_prev = 1'b0;
    for (int i = 0; i < N; i++) waited[i] = 0;
    @(posedge clk); #1;
    want[0] = a; want[1] = b; want[2] = c; want[3] = d;
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() == 0 && !pending && busy == 0 &&
          want[0] == 0 && want[1] == 0 && want[2] == 0 && want[3] == 0) break;
    end
    repeat (6) @(posedge clk);
    #1;
    chk(gnt == N'(1 << l), "R3 grant parked on last owner", int'(gnt), 1 << l);
    parked   = l;
    last_own = l;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(gnt == N'(1), "R9 grant during reset", int'(gnt), 1);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(gnt == N'(1), "R9 grant after reset with no requests", int'(gnt), 1);
    run4(0, 0, 1, 0);
    run4(2, 2, 2, 2);
    run4(0, 0, 0, 3);   // R8 sole requester back to back
    run4(3, 0, 1, 0);
    run4(1, 4, 1, 1);   // R7 long requester
    run4(0, 3, 0, 2);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      ncyc++;
      if (ncyc > 50000 && !done) begin
        nchk++;
        nerr++;
        $display("FAIL watchdog R4 run did not complete actual=%0d expected=%0d", ncyc, 50000);
        summary();
        $finish;
      end
    end
  end
endmodule